// File: doc/BRIEF.md
# Multi-Source Sensor Pixel Packer

The block takes 10-bit monochrome pixels from up to three parallel camera inputs and forwards exactly one of them. Each input has a pixel strobe, a frame-active level, a line-active level and a pixel bus. The pixel strobe marks the core-clock cycles in which the sensor's pixel clock presents a new sample. The block collects three consecutive pixels of the chosen input into one 32-bit word. It pushes each word into a small output queue, and the queue feeds a downstream stream port with valid/ready handshaking. The first word of every frame carries a start-of-frame marker. A line whose pixel count is not a multiple of three ends with a partial word whose empty fields are zero. With a 752-pixel line, this gives 250 full words and one final word holding two pixels.

The input is chosen with a select input, but the block only adopts a new value while the currently chosen input is between frames, so a frame never mixes two sources. After a switch, and after reset, the packer waits until the new input is itself outside a frame before it accepts anything. This prevents it from capturing the tail of a frame that was already running. If a word must be stored while the queue is full and the downstream is not ready, the word is dropped and a sticky overflow flag is raised. A one-cycle clear pulse lowers the flag.

The packer is a five-state machine:
- ST_SYNC waits for the chosen input to leave its frame.
- ST_IDLE is between frames. It moves to ST_SYNC on a source switch, or on frame start to ST_EMPTY, or to ST_HAVE1 if a pixel arrives in the same cycle.
- ST_EMPTY is inside a frame with no pixels held. It moves to ST_HAVE1 on a pixel and to ST_IDLE when the frame ends.
- ST_HAVE1 holds one pixel and ST_HAVE2 holds two. A pixel moves ST_HAVE1 to ST_HAVE2, and moves ST_HAVE2 back to ST_EMPTY while emitting a full word.
- In ST_HAVE1 or ST_HAVE2, the end of a line or frame emits the partial word. The machine then goes to ST_EMPTY, or to ST_IDLE if the frame has ended.

Top module: `sensor_pixel_packer`

## Requirements
- R1: Output word layout: first pixel of a group in bits 9:0, second in bits 19:10, third in bits 29:20; bits 31:30 are always zero.
- R2: A sample is taken only in a cycle where the chosen input's pixel strobe, frame-active and line-active are all high; bus values in any other cycle have no effect on the output.
- R3: When line-active or frame-active drops while one or two pixels are held, a word is emitted with those pixels in the lowest fields and the unused pixel fields zero.
- R4: m_sof is high on the first word produced after frame-active rises and low on every other word of the frame.
- R5: A 752-pixel line yields exactly 251 words, the last holding two pixels with bits 29:20 zero.
- R6: A change of the select input is adopted only while the currently chosen input's frame-active is low; a frame in progress finishes on its original source.
- R7: After a source switch, pixels of the new source are ignored until its frame-active has been seen low; capture starts with its next full frame.
- R8: A select value of 3 or more (no such input) is ignored and the current source stays chosen.
- R9: While m_valid is high and m_ready is low, m_data and m_sof hold their values; words leave in production order with none lost while the queue has room.
- R10: A word produced while the queue is full and m_ready is low is dropped and ovf_flag goes high; ovf_flag stays high until a cycle with ovf_clear high, after which it is low (clear wins over a new overflow in the same cycle).
- R11: During and right after reset, m_valid and ovf_flag are low and input 0 is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 3 | Per-input pixel strobe (one core cycle per sensor pixel clock) |
| src_fv | input | 3 | Per-input frame-active level |
| src_lv | input | 3 | Per-input line-active level |
| src_pix | input | 30 | Per-input 10-bit pixel buses, input i in bits 10*i+9:10*i |
| src_sel | input | 2 | Requested input number |
| ovf_clear | input | 1 | One-cycle pulse that clears the overflow flag |
| m_ready | input | 1 | Downstream ready |
| m_valid | output | 1 | Output word valid |
| m_data | output | 32 | Packed word of three pixels |
| m_sof | output | 1 | Word is the first of a frame |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach is a source switch that lands while the newly chosen sensor is already inside a frame. The old input must be idle, and the new one must be streaming at the moment the switch is taken. The stimulus raises frame-active on input 1 first and only then requests input 1. It drives a full line on input 1 that must vanish, then a fresh frame that must appear with its start marker. The mid-frame select change is reached by running two sensors at once in forked processes and changing the select halfway through the frame on input 1.

// File: rtl/spk_pkg.sv
package spk_pkg;
    typedef enum logic [2:0] {
        ST_SYNC  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_EMPTY = 3'd2,
        ST_HAVE1 = 3'd3,
        ST_HAVE2 = 3'd4
    } pack_state_e;
endpackage

// File: rtl/spk_src_mux.sv
module spk_src_mux #(
    parameter int NUM_SRC = 3,
    parameter int PIX_W   = 10,
    parameter int SEL_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC-1:0]       src_fv,
    input  logic [NUM_SRC-1:0]       src_lv,
    input  logic [NUM_SRC*PIX_W-1:0] src_pix,
    input  logic [SEL_W-1:0]         req_sel,
    input  logic                     may_switch,
    output logic [SEL_W-1:0]         act_sel,
    output logic                     switched,
    output logic                     sel_en,
    output logic                     sel_fv,
    output logic                     sel_lv,
    output logic [PIX_W-1:0]         sel_pix
);
    localparam logic [SEL_W:0] SRC_LIM = (SEL_W+1)'(NUM_SRC);

    logic req_ok;

    // a request is legal only when it names an existing, different input
    assign req_ok   = ({1'b0, req_sel} < SRC_LIM) && (req_sel != act_sel);
    assign switched = may_switch && req_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_sel <= '0;
        end else if (switched) begin
            act_sel <= req_sel;
        end
    end

    always_comb begin
        sel_en  = 1'b0;
        sel_fv  = 1'b0;
        sel_lv  = 1'b0;
        sel_pix = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act_sel == SEL_W'(i)) begin
                sel_en  = src_en[i];
                sel_fv  = src_fv[i];
                sel_lv  = src_lv[i];
                sel_pix = src_pix[i*PIX_W +: PIX_W];
            end
        end
    end
endmodule

// File: rtl/spk_pack_fsm.sv
module spk_pack_fsm
    import spk_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              fv,
    input  logic              lv,
    input  logic [PIX_W-1:0]  pix,
    input  logic              src_switch,
    output pack_state_e       st,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic              push_sof
);
    localparam int GROUP_W = 3 * PIX_W;

    pack_state_e      nxt;
    logic [PIX_W-1:0] hold0;
    logic [PIX_W-1:0] hold1;
    logic             sof_pend;
    logic             acc;
    logic             line_end;

    function automatic logic [WORD_W-1:0] pack3(input logic [PIX_W-1:0] a,
                                                input logic [PIX_W-1:0] b,
                                                input logic [PIX_W-1:0] c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[GROUP_W-1:0] = {c, b, a};
        return w;
    endfunction

    assign acc      = pix_en && fv && lv && (st != ST_SYNC);
    assign line_end = !(fv && lv);
    assign push_sof = sof_pend;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_SYNC;
        end else begin
            st <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_SYNC:  if (!fv) nxt = ST_IDLE;
            ST_IDLE: begin
                if (src_switch)  nxt = ST_SYNC;
                else if (fv)     nxt = acc ? ST_HAVE1 : ST_EMPTY;
            end
            ST_EMPTY: begin
                if (!fv)         nxt = ST_IDLE;
                else if (acc)    nxt = ST_HAVE1;
            end
            ST_HAVE1: begin
                if (acc)           nxt = ST_HAVE2;
                else if (line_end) nxt = fv ? ST_EMPTY : ST_IDLE;
            end
            ST_HAVE2: begin
                if (acc)           nxt = ST_EMPTY;
                else if (line_end) nxt = fv ? ST_EMPTY : ST_IDLE;
            end
            default:             nxt = ST_SYNC;
        endcase
    end

    // outputs: word emission
    always_comb begin
        push      = 1'b0;
        push_word = '0;
        unique case (st)
            ST_HAVE1: begin
                if (line_end) begin
                    push      = 1'b1;
                    push_word = pack3(hold0, '0, '0);
                end
            end
            ST_HAVE2: begin
                if (acc) begin
                    push      = 1'b1;
                    push_word = pack3(hold0, hold1, pix);
                end else if (line_end) begin
                    push      = 1'b1;
                    push_word = pack3(hold0, hold1, '0);
                end
            end
            default: ;
        endcase
    end

    // held pixels and start-of-frame marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold0    <= '0;
            hold1    <= '0;
            sof_pend <= 1'b0;
        end else begin
            if (acc && (st == ST_IDLE || st == ST_EMPTY)) hold0 <= pix;
            if (acc && st == ST_HAVE1)                   hold1 <= pix;
            if (push)                                     sof_pend <= 1'b0;
            else if (st == ST_IDLE && fv)                 sof_pend <= 1'b1;
            else if (st == ST_EMPTY && !fv)               sof_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/spk_word_fifo.sv
module spk_word_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         full,
    output logic         valid,
    output logic [W-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign valid   = (cnt != '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_pop  = valid && ready;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/sensor_pixel_packer.sv
module sensor_pixel_packer
    import spk_pkg::*;
#(
    parameter int NUM_SRC    = 3,
    parameter int PIX_W      = 10,
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC-1:0]       src_fv,
    input  logic [NUM_SRC-1:0]       src_lv,
    input  logic [NUM_SRC*PIX_W-1:0] src_pix,
    input  logic [SEL_W-1:0]         src_sel,
    input  logic                     ovf_clear,
    input  logic                     m_ready,
    output logic                     m_valid,
    output logic [WORD_W-1:0]        m_data,
    output logic                     m_sof,
    output logic                     ovf_flag
);
    localparam int ENTRY_W = WORD_W + 1;

    pack_state_e       st;
    logic [SEL_W-1:0]  act_sel;
    logic              switched;
    logic              sel_en;
    logic              sel_fv;
    logic              sel_lv;
    logic [PIX_W-1:0]  sel_pix;
    logic              push;
    logic [WORD_W-1:0] push_word;
    logic              push_sof;
    logic              q_full;
    logic [ENTRY_W-1:0] q_out;
    logic              may_switch;

    assign may_switch = (st == ST_IDLE) && !sel_fv;

    spk_src_mux #(.NUM_SRC(NUM_SRC), .PIX_W(PIX_W), .SEL_W(SEL_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_en     (src_en),
        .src_fv     (src_fv),
        .src_lv     (src_lv),
        .src_pix    (src_pix),
        .req_sel    (src_sel),
        .may_switch (may_switch),
        .act_sel    (act_sel),
        .switched   (switched),
        .sel_en     (sel_en),
        .sel_fv     (sel_fv),
        .sel_lv     (sel_lv),
        .sel_pix    (sel_pix)
    );

    spk_pack_fsm #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_en     (sel_en),
        .fv         (sel_fv),
        .lv         (sel_lv),
        .pix        (sel_pix),
        .src_switch (switched),
        .st         (st),
        .push       (push),
        .push_word  (push_word),
        .push_sof   (push_sof)
    );

    spk_word_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({push_sof, push_word}),
        .ready (m_ready),
        .full  (q_full),
        .valid (m_valid),
        .dout  (q_out)
    );

    assign m_data = q_out[WORD_W-1:0];
    assign m_sof  = q_out[WORD_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (ovf_clear) begin
            ovf_flag <= 1'b0;
        end else if (push && q_full && !m_ready) begin
            ovf_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/spk_checker.sv
module spk_checker
    import spk_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int WORD_W = 32,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_valid,
    input logic              m_ready,
    input logic [WORD_W-1:0] m_data,
    input logic              m_sof,
    input logic              ovf_flag,
    input logic              ovf_clear,
    input logic [SEL_W-1:0]  act_sel,
    input pack_state_e       st
);
    assert_spare_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> ((m_data >> (3 * PIX_W)) == '0));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sof)));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clear) |=> ovf_flag);

    assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clear |=> !ovf_flag);

    assert_sel_between_frames_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_sel) |-> ($past(st) == ST_IDLE));

    assert_sync_after_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_sel) |-> (st == ST_SYNC));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |-> (!m_valid && !ovf_flag && act_sel == '0));
endmodule

bind sensor_pixel_packer spk_checker #(.PIX_W(PIX_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_sof     (m_sof),
    .ovf_flag  (ovf_flag),
    .ovf_clear (ovf_clear),
    .act_sel   (act_sel),
    .st        (st)
);

// File: tb/test_sensor_pixel_packer.sv
module test_sensor_pixel_packer;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    localparam logic [9:0] LEN_TAB   [0:7] = '{10'd3, 10'd4, 10'd5, 10'd6, 10'd1, 10'd2, 10'd7, 10'd9};
    localparam logic [3:0] GAP_TAB   [0:7] = '{4'd0, 4'd0, 4'd1, 4'd2, 4'd0, 4'd3, 4'd0, 4'd1};
    localparam logic [3:0] WORDS_TAB [0:7] = '{4'd1, 4'd2, 4'd2, 4'd2, 4'd1, 4'd1, 4'd3, 4'd3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_en = '0;
    logic [2:0]  src_fv = '0;
    logic [2:0]  src_lv = '0;
    logic [29:0] src_pix = '0;
    logic [1:0]  src_sel = '0;
    logic        ovf_clear = 1'b0;
    logic        rdy_man = 1'b1;
    logic        bp_on = 1'b0;
    logic [3:0]  bpc = '0;
    logic        m_ready;
    logic        m_valid;
    logic [31:0] m_data;
    logic        m_sof;
    logic        ovf_flag;

    logic [32:0] got[$];
    logic [32:0] exp_q[$];
    int          errors = 0;
    int          checks = 0;
    int          cyc = 0;
    bit          sof_next = 1'b0;
    logic [9:0]  grp[$];

    assign m_ready = bp_on ? bpc[1] : rdy_man;

    sensor_pixel_packer i_sensor_pixel_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en    (src_en),
        .src_fv    (src_fv),
        .src_lv    (src_lv),
        .src_pix   (src_pix),
        .src_sel   (src_sel),
        .ovf_clear (ovf_clear),
        .m_ready   (m_ready),
        .m_valid   (m_valid),
        .m_data    (m_data),
        .m_sof     (m_sof),
        .ovf_flag  (ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        bpc = bpc + 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n && m_valid && m_ready) got.push_back({m_sof, m_data});
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WDOG_LIMIT) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WDOG_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [9:0] pixval(input int base, input int k);
        return 10'((base + k * 37) % 1024);
    endfunction

    // reference word: pixels low to high, two spare bits on top
    task automatic model_emit();
        logic [9:0] a, b, c;
        a = (grp.size() > 0) ? grp[0] : 10'd0;
        b = (grp.size() > 1) ? grp[1] : 10'd0;
        c = (grp.size() > 2) ? grp[2] : 10'd0;
        exp_q.push_back({sof_next, 2'b00, c, b, a});
        sof_next = 1'b0;
        grp.delete();
    endtask

    task automatic drive_line(input int s, input int n, input int base, input int gap,
                              input bit drop_fv, input bit rec);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            src_lv[s] = 1'b1;
            src_en[s] = 1'b1;
            src_pix[s*10 +: 10] = pixval(base, k);
            if (rec) begin
                grp.push_back(pixval(base, k));
                if (grp.size() == 3) model_emit();
            end
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1;
                src_en[s] = 1'b0;
                src_pix[s*10 +: 10] = 10'h3FF;
            end
        end
        @(posedge clk); #1;
        src_en[s] = 1'b0;
        src_lv[s] = 1'b0;
        if (drop_fv) src_fv[s] = 1'b0;
        if (rec && grp.size() > 0) model_emit();
        @(posedge clk);
    endtask

    task automatic frame_begin(input int s);
        @(posedge clk); #1;
        src_fv[s] = 1'b1;
        sof_next = 1'b1;
    endtask

    task automatic frame_end(input int s);
        @(posedge clk); #1;
        src_fv[s] = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic drain(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmp_stream(input string req);
        int n;
        chk(got.size() == exp_q.size(), {req, " word count"}, got.size(), exp_q.size());
        n = (got.size() < exp_q.size()) ? got.size() : exp_q.size();
        for (int i = 0; i < n; i++) begin
            chk(got[i] === exp_q[i], {req, " word"}, got[i], exp_q[i]);
        end
        got.delete();
        exp_q.delete();
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!m_valid && !ovf_flag, "R11 in reset", {m_valid, ovf_flag}, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!m_valid && !ovf_flag, "R11 after reset", {m_valid, ovf_flag}, 0);

        // table walk: R1 R3 R4 over line lengths and strobe gaps
        for (int v = 0; v < 8; v++) begin
            frame_begin(0);
            drive_line(0, int'(LEN_TAB[v]), v * 50 + 3, int'(GAP_TAB[v]), 1'b0, 1'b1);
            frame_end(0);
            drain(8);
            chk(got.size() == int'(WORDS_TAB[v]), "R1 R3 table word count", got.size(), WORDS_TAB[v]);
            cmp_stream("R1 R3 R4 table");
        end

        // R4: two lines in one frame, marker only on first word
        frame_begin(0);
        drive_line(0, 4, 100, 0, 1'b0, 1'b1);
        drive_line(0, 5, 200, 1, 1'b0, 1'b1);
        frame_end(0);
        drain(8);
        cmp_stream("R4 multi-line");

        // R3: frame and line drop in the same cycle with one pixel held
        frame_begin(0);
        drive_line(0, 4, 300, 0, 1'b1, 1'b1);
        repeat (3) @(posedge clk);
        drain(8);
        cmp_stream("R3 frame-drop flush");

        // R2: strobes outside frame or outside line are ignored
        @(posedge clk); #1;
        src_lv[0] = 1'b1; src_en[0] = 1'b1; src_pix[9:0] = 10'h155;
        repeat (3) @(posedge clk); #1;
        src_lv[0] = 1'b0; src_en[0] = 1'b0;
        frame_begin(0);
        @(posedge clk); #1;
        src_en[0] = 1'b1; src_pix[9:0] = 10'h2AA;
        repeat (3) @(posedge clk); #1;
        src_en[0] = 1'b0;
        drive_line(0, 3, 400, 0, 1'b0, 1'b1);
        frame_end(0);
        drain(8);
        cmp_stream("R2 ignored samples");

        // R5: full 752-pixel line
        frame_begin(0);
        drive_line(0, 752, 7, 0, 1'b0, 1'b1);
        frame_end(0);
        drain(10);
        chk(got.size() == 251, "R5 words per line", got.size(), 251);
        if (got.size() == 251) begin
            chk(got[250][29:20] == 10'd0, "R5 last word third field", got[250][29:20], 0);
        end
        cmp_stream("R5 full line");

        // R8: nonexistent source number ignored
        src_sel = 2'd3;
        repeat (3) @(posedge clk);
        frame_begin(0);
        drive_line(0, 5, 500, 0, 1'b0, 1'b1);
        frame_end(0);
        drain(8);
        cmp_stream("R8 bad select");

        // R7: switch onto a source already mid-frame
        @(posedge clk); #1;
        src_fv[1] = 1'b1;
        @(posedge clk); #1;
        src_sel = 2'd1;
        drive_line(1, 6, 600, 0, 1'b0, 1'b0);
        @(posedge clk); #1;
        src_fv[1] = 1'b0;
        repeat (3) @(posedge clk);
        frame_begin(1);
        drive_line(1, 4, 700, 0, 1'b0, 1'b1);
        frame_end(1);
        drain(8);
        cmp_stream("R7 switch into running frame");

        // R6: select changed mid-frame while another sensor streams
        frame_begin(1);
        drive_line(1, 3, 800, 0, 1'b0, 1'b1);
        @(posedge clk); #1;
        src_sel = 2'd0;
        fork
            begin
                @(posedge clk); #1;
                src_fv[0] = 1'b1;
                drive_line(0, 6, 850, 0, 1'b0, 1'b0);
                @(posedge clk); #1;
                src_fv[0] = 1'b0;
            end
            drive_line(1, 5, 900, 0, 1'b0, 1'b1);
        join
        frame_end(1);
        frame_begin(0);
        drive_line(0, 4, 950, 0, 1'b0, 1'b1);
        frame_end(0);
        drain(8);
        cmp_stream("R6 deferred select");

        // R9: toggling ready, order and content kept
        bp_on = 1'b1;
        frame_begin(0);
        drive_line(0, 15, 111, 0, 1'b0, 1'b1);
        frame_end(0);
        drain(20);
        bp_on = 1'b0;
        cmp_stream("R9 backpressure");
        chk(!ovf_flag, "R9 no overflow under backpressure", ovf_flag, 0);

        // R10: overflow with ready held low
        rdy_man = 1'b0;
        frame_begin(0);
        drive_line(0, 15, 222, 0, 1'b0, 1'b1);
        frame_end(0);
        drain(4);
        chk(ovf_flag == 1'b1, "R10 overflow raised", ovf_flag, 1);
        void'(exp_q.pop_back());
        drain(10);
        chk(ovf_flag == 1'b1, "R10 overflow sticky", ovf_flag, 1);
        chk(m_valid == 1'b1, "R9 word held while not ready", m_valid, 1);
        rdy_man = 1'b1;
        drain(10);
        cmp_stream("R10 dropped newest word");
        chk(ovf_flag == 1'b1, "R10 sticky after drain", ovf_flag, 1);
        @(posedge clk); #1;
        ovf_clear = 1'b1;
        @(posedge clk); #1;
        ovf_clear = 1'b0;
        @(negedge clk);
        chk(ovf_flag == 1'b0, "R10 cleared", ovf_flag, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule